// File: doc/BRIEF.md
# Camera-Serial Transmitter Control and Interrupt Register Bank

This block is the software-facing register bank of a camera-serial transmitter. It is an AXI4-Lite slave that stores the settings the transmit datapath runs with: core enable, soft reset, clock mode, the low-power request, line-sync generation and the number of active lanes. It also reports the fixed lane ceiling and pixel mode chosen when the block is built.

The datapath reports events as single-cycle pulses. These events, together with checks the bank makes on its own register writes, set sticky status bits. Software clears a status bit by writing 1 to it. Each status bit has its own enable, and a global enable sits above them all. The enabled bits drive one registered, level-sensitive interrupt line.

Software can queue generic short packet requests in a four-entry FIFO. The datapath drains this FIFO through a valid/pop pair. Settings written while the core is disabled are staged and do not reach the datapath until the core is enabled.

Top module: `cstx_regbank`

## Requirements
- R1: Only address bits 6:0 select a register, so 0x80 reaches the same register as 0x00. Reads of unmapped offsets return 0. Every write and read completes with an OKAY (0) response.
- R2: The core register at 0x00 holds these bits: bit 0 enable, bit 1 soft reset, bit 2 read-only ready (mirrors input `dp_ready_i`), bit 3 low-power entry request, bit 4 clock mode (1 = non-continuous). After reset it reads 0x4 while `dp_ready_i` is 1.
- R3: The protocol register at 0x04 holds these bits: bits 1:0 active lanes minus one (read/write, resets to the maximum), bits 4:3 read-only maximum lanes minus one (`MAX_LANES-1`), bits 14:13 read-only pixel mode (`PIX_MODE`), bit 15 line-sync generation enable. With the default parameters it reads 0x9 after reset.
- R4: Writes to the staged settings (active lanes, line sync, clock mode, low-power request) read back at once. They reach the datapath outputs only while the core is enabled, within two cycles of the write or of enabling the core.
- R5: Status register 0x24 uses these bits: 0 pixel underrun, 1 unsupported packet type, 2 line buffer full, 3 low-power state, 4 packet FIFO full, 5 bad lane count. A bit stays set until a write of 1 to that bit position. Writing 0 to a bit has no effect.
- R6: Interrupt enable register 0x28 uses the same bit positions as the status register. A disabled bit is still captured in the status register but does not raise `irq_o`.
- R7: Global enable 0x20 bit 0 masks `irq_o` entirely. `irq_o` equals the global enable ANDed with the OR of (status AND enable), delayed by one register stage.
- R8: While soft reset is 1 the status register reads 0 and ignores events. Capture resumes after soft reset is written back to 0.
- R9: A write to 0x30 is a packet request with data type in bits 5:0, virtual channel in bits 7:6 and payload in bits 23:8. With the core enabled, a request with data type 0x08 to 0x0F is queued. Any other data type sets status bit 1 and is not queued. With the core disabled, the request is discarded with no status change.
- R10: A write to 0x04 whose active-lane field exceeds the maximum-lane field sets status bit 5.
- R11: The FIFO holds 4 entries in order. Register 0x78 reports bit 0 empty, bit 1 full and bits 4:2 the entry count. A request written while the FIFO is full is dropped and sets status bit 4. The datapath removes the head entry by pulsing `gsp_pop_i` while `gsp_valid_o` is 1.
- R12: Write strobes are ignored: a write with `s_wstrb` = 0 updates the whole register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| s_awaddr | input | ADDR_W | Write address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | 32 | Write data |
| s_wstrb | input | 4 | Write strobes (ignored) |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | ADDR_W | Read address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| dp_ready_i | input | 1 | Datapath idle/ready indication |
| ev_underrun_i | input | 1 | Pixel underrun event pulse |
| ev_linebuf_full_i | input | 1 | Line buffer full event pulse |
| ev_lowpower_i | input | 1 | Lanes entered low-power state event pulse |
| core_en_o | output | 1 | Core enable |
| lp_req_o | output | 1 | Effective low-power entry request |
| clk_noncont_o | output | 1 | Effective clock mode |
| line_sync_en_o | output | 1 | Effective line-sync generation enable |
| active_lanes_o | output | 2 | Effective active lanes minus one |
| gsp_valid_o | output | 1 | Packet FIFO holds an entry |
| gsp_pkt_o | output | 24 | Head packet request |
| gsp_pop_i | input | 1 | Remove head packet request |
| irq_o | output | 1 | Level interrupt |

## Verification
The hardest state to reach is a FIFO overflow that happens while other status bits are also live. The FIFO can only be filled by register writes, and those writes are accepted only while the core is enabled and only with a legal data type. The stimulus therefore enables the core, pushes four legal requests without popping, and then writes a fifth. It checks that the count stays at four, that the FIFO-full status bit rises, and that the entries drain in order. Staged configuration is driven with the core disabled so that the readback and the datapath outputs differ. Enabling the core then shows them converge.

// File: rtl/cstx_pkg.sv
// Shared offsets, status bit positions and packet layout for the
// transmitter register bank. Assumes a 32-bit data bus.
package cstx_pkg;
    localparam int unsigned DATA_W  = 32;
    localparam int unsigned OFS_W   = 7;
    localparam int unsigned NSTAT   = 6;

    localparam logic [OFS_W-1:0] OFS_CORE  = 7'h00;
    localparam logic [OFS_W-1:0] OFS_PROTO = 7'h04;
    localparam logic [OFS_W-1:0] OFS_GIE   = 7'h20;
    localparam logic [OFS_W-1:0] OFS_ISR   = 7'h24;
    localparam logic [OFS_W-1:0] OFS_IER   = 7'h28;
    localparam logic [OFS_W-1:0] OFS_GSP   = 7'h30;
    localparam logic [OFS_W-1:0] OFS_GSPST = 7'h78;

    localparam int unsigned ST_UNDERRUN = 0;
    localparam int unsigned ST_BAD_DT   = 1;
    localparam int unsigned ST_LINEBUF  = 2;
    localparam int unsigned ST_LOWPWR   = 3;
    localparam int unsigned ST_GSP_FULL = 4;
    localparam int unsigned ST_BAD_LANE = 5;

    typedef struct packed {
        logic [15:0] payload;
        logic [1:0]  vc;
        logic [5:0]  dt;
    } gsp_pkt_t;

    localparam int unsigned PKT_W = $bits(gsp_pkt_t);
endpackage

// File: rtl/cstx_axil_if.sv
// AXI4-Lite slave front end. Accepts one write (address and data together)
// and one read at a time, always answers OKAY. Only the low OFS_W address
// bits reach the register decode. Assumes ADDR_W > OFS_W.
module cstx_axil_if
    import cstx_pkg::*;
#(
    parameter int unsigned ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] awaddr,
    input  logic              awvalid,
    output logic              awready,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wvalid,
    output logic              wready,
    output logic [1:0]        bresp,
    output logic              bvalid,
    input  logic              bready,
    input  logic [ADDR_W-1:0] araddr,
    input  logic              arvalid,
    output logic              arready,
    output logic [DATA_W-1:0] rdata,
    output logic [1:0]        rresp,
    output logic              rvalid,
    input  logic              rready,
    output logic              wr_en,
    output logic [OFS_W-1:0]  wr_ofs,
    output logic [DATA_W-1:0] wr_data,
    output logic              rd_en,
    output logic [OFS_W-1:0]  rd_ofs,
    input  logic [DATA_W-1:0] rd_data
);
    logic unused_addr_hi;

    // Upper address bits are deliberately not decoded.
    assign unused_addr_hi = ^{awaddr[ADDR_W-1:OFS_W], araddr[ADDR_W-1:OFS_W]};

    // Ready while no response is outstanding.
    assign awready = !bvalid;
    assign wready  = !bvalid;
    assign arready = !rvalid;

    assign wr_en   = awvalid && wvalid && !bvalid;
    assign wr_ofs  = awaddr[OFS_W-1:0];
    assign wr_data = wdata;
    assign rd_en   = arvalid && !rvalid;
    assign rd_ofs  = araddr[OFS_W-1:0];
    assign bresp   = 2'b00;
    assign rresp   = 2'b00;

    // Write response channel.
    always_ff @(posedge clk) begin
        if (!rst_n)       bvalid <= 1'b0;
        else if (wr_en)   bvalid <= 1'b1;
        else if (bready)  bvalid <= 1'b0;
    end

    // Read data channel, data captured at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rvalid <= 1'b0;
            rdata  <= '0;
        end else if (rd_en) begin
            rvalid <= 1'b1;
            rdata  <= rd_data;
        end else if (rready) begin
            rvalid <= 1'b0;
        end
    end

    AST_BVALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        bvalid && !bready |=> bvalid);                              // R1
    AST_RVALID_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid && !rready |=> rvalid && $stable(rdata));            // R1
endmodule

// File: rtl/cstx_isr.sv
// Sticky status register with write-one-to-clear, soft-reset clear and a
// registered, masked interrupt output. Set wins over a same-cycle clear.
module cstx_isr #(
    parameter int unsigned NBITS = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NBITS-1:0] set_i,
    input  logic             clr_wr_i,
    input  logic [NBITS-1:0] clr_data_i,
    input  logic             soft_rst_i,
    input  logic [NBITS-1:0] ier_i,
    input  logic             gie_i,
    output logic [NBITS-1:0] status_o,
    output logic             irq_o
);
    logic [NBITS-1:0] clr_mask;

    assign clr_mask = clr_wr_i ? clr_data_i : '0;

    // Status capture and clearing.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst_i) status_o <= '0;
        else                      status_o <= (status_o & ~clr_mask) | set_i;
    end

    // Registered interrupt level.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_o <= 1'b0;
        else        irq_o <= gie_i && |(status_o & ier_i);
    end

    AST_SRST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst_i |=> status_o == '0);                             // R8
    AST_GIE_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        !gie_i |=> !irq_o);                                         // R7
    AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !soft_rst_i && !clr_wr_i |=> (status_o & $past(status_o)) == $past(status_o)); // R5
endmodule

// File: rtl/cstx_gsp_fifo.sv
// Small in-order FIFO for packet requests. A push while full is refused
// and flagged on drop_o; a pop while empty is ignored.
module cstx_gsp_fifo #(
    parameter int unsigned DEPTH = 4,
    parameter int unsigned W     = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push_i,
    input  logic [W-1:0] data_i,
    input  logic         pop_i,
    output logic [W-1:0] head_o,
    output logic         empty_o,
    output logic         full_o,
    output logic         drop_o,
    output logic [$clog2(DEPTH+1)-1:0] count_o
);
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CNT_W = $clog2(DEPTH+1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH-1);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic             push_ok, pop_ok;

    assign empty_o = (count_o == '0);
    assign full_o  = (count_o == CNT_W'(DEPTH));
    assign push_ok = push_i && !full_o;
    assign pop_ok  = pop_i && !empty_o;
    assign drop_o  = push_i && full_o;
    assign head_o  = mem[rd_ptr];

    // Storage write.
    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= data_i;
    end

    // Pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            count_o <= '0;
        end else begin
            if (push_ok) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (pop_ok)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            count_o <= count_o + CNT_W'(push_ok) - CNT_W'(pop_ok);
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        count_o <= CNT_W'(DEPTH));                                  // R11
    AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        full_o && push_i && !pop_i |=> count_o == $past(count_o));  // R11
endmodule

// File: rtl/cstx_regbank.sv
// Control, status and interrupt register bank of a camera-serial
// transmitter. Staged settings reach the datapath only while the core
// is enabled. Event inputs are single-cycle pulses from the datapath.
module cstx_regbank
    import cstx_pkg::*;
#(
    parameter int unsigned ADDR_W    = 12,
    parameter int unsigned MAX_LANES = 2,
    parameter int unsigned PIX_MODE  = 0,
    parameter int unsigned GSP_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] s_awaddr,
    input  logic              s_awvalid,
    output logic              s_awready,
    input  logic [31:0]       s_wdata,
    input  logic [3:0]        s_wstrb,
    input  logic              s_wvalid,
    output logic              s_wready,
    output logic [1:0]        s_bresp,
    output logic              s_bvalid,
    input  logic              s_bready,
    input  logic [ADDR_W-1:0] s_araddr,
    input  logic              s_arvalid,
    output logic              s_arready,
    output logic [31:0]       s_rdata,
    output logic [1:0]        s_rresp,
    output logic              s_rvalid,
    input  logic              s_rready,
    input  logic              dp_ready_i,
    input  logic              ev_underrun_i,
    input  logic              ev_linebuf_full_i,
    input  logic              ev_lowpower_i,
    output logic              core_en_o,
    output logic              lp_req_o,
    output logic              clk_noncont_o,
    output logic              line_sync_en_o,
    output logic [1:0]        active_lanes_o,
    output logic              gsp_valid_o,
    output logic [23:0]       gsp_pkt_o,
    input  logic              gsp_pop_i,
    output logic              irq_o
);
    localparam logic [1:0] MAX_CODE = 2'(MAX_LANES - 1);
    localparam logic [1:0] PIX_CODE = 2'(PIX_MODE);
    localparam int unsigned CNT_W   = $clog2(GSP_DEPTH + 1);

    logic              wr_en, rd_en;
    logic [OFS_W-1:0]  wr_ofs, rd_ofs;
    logic [DATA_W-1:0] wr_data, rd_data;
    logic              unused_wstrb;

    logic              en_q, srst_q, gie_q;
    logic              lp_s, clkm_s, lsync_s;
    logic [1:0]        lanes_s;
    logic [NSTAT-1:0]  ier_q, isr_q, set_vec;

    logic              gsp_wr, dt_ok, fifo_push, fifo_empty, fifo_full, fifo_drop;
    logic              lane_bad;
    logic [CNT_W-1:0]  fifo_cnt;
    gsp_pkt_t          req_pkt, head_pkt;

    assign unused_wstrb = ^s_wstrb;

    cstx_axil_if #(.ADDR_W(ADDR_W)) u_axil (
        .clk(clk), .rst_n(rst_n),
        .awaddr(s_awaddr), .awvalid(s_awvalid), .awready(s_awready),
        .wdata(s_wdata), .wvalid(s_wvalid), .wready(s_wready),
        .bresp(s_bresp), .bvalid(s_bvalid), .bready(s_bready),
        .araddr(s_araddr), .arvalid(s_arvalid), .arready(s_arready),
        .rdata(s_rdata), .rresp(s_rresp), .rvalid(s_rvalid), .rready(s_rready),
        .wr_en(wr_en), .wr_ofs(wr_ofs), .wr_data(wr_data),
        .rd_en(rd_en), .rd_ofs(rd_ofs), .rd_data(rd_data)
    );

    // Register writes: enable and soft reset act at once, the rest is staged.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q    <= 1'b0;
            srst_q  <= 1'b0;
            lp_s    <= 1'b0;
            clkm_s  <= 1'b0;
            lsync_s <= 1'b0;
            lanes_s <= MAX_CODE;
            gie_q   <= 1'b0;
            ier_q   <= '0;
        end else if (wr_en) begin
            case (wr_ofs)
                OFS_CORE: begin
                    en_q   <= wr_data[0];
                    srst_q <= wr_data[1];
                    lp_s   <= wr_data[3];
                    clkm_s <= wr_data[4];
                end
                OFS_PROTO: begin
                    lanes_s <= wr_data[1:0];
                    lsync_s <= wr_data[15];
                end
                OFS_GIE: gie_q <= wr_data[0];
                OFS_IER: ier_q <= wr_data[NSTAT-1:0];
                default: ;
            endcase
        end
    end

    // Effective settings follow the staged ones only while enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lp_req_o       <= 1'b0;
            clk_noncont_o  <= 1'b0;
            line_sync_en_o <= 1'b0;
            active_lanes_o <= MAX_CODE;
        end else if (en_q) begin
            lp_req_o       <= lp_s;
            clk_noncont_o  <= clkm_s;
            line_sync_en_o <= lsync_s;
            active_lanes_o <= lanes_s;
        end
    end

    assign core_en_o = en_q;

    // Packet request validation and event collection.
    assign req_pkt   = gsp_pkt_t'(wr_data[PKT_W-1:0]);
    assign gsp_wr    = wr_en && (wr_ofs == OFS_GSP);
    assign dt_ok     = (req_pkt.dt[5:3] == 3'b001);
    assign fifo_push = gsp_wr && en_q && dt_ok;
    assign lane_bad  = wr_en && (wr_ofs == OFS_PROTO) && (wr_data[1:0] > MAX_CODE);

    always_comb begin
        set_vec              = '0;
        set_vec[ST_UNDERRUN] = ev_underrun_i;
        set_vec[ST_BAD_DT]   = gsp_wr && en_q && !dt_ok;
        set_vec[ST_LINEBUF]  = ev_linebuf_full_i;
        set_vec[ST_LOWPWR]   = ev_lowpower_i;
        set_vec[ST_GSP_FULL] = fifo_drop && en_q && dt_ok;
        set_vec[ST_BAD_LANE] = lane_bad;
    end

    cstx_isr #(.NBITS(NSTAT)) u_isr (
        .clk(clk), .rst_n(rst_n),
        .set_i(set_vec),
        .clr_wr_i(wr_en && (wr_ofs == OFS_ISR)),
        .clr_data_i(wr_data[NSTAT-1:0]),
        .soft_rst_i(srst_q),
        .ier_i(ier_q), .gie_i(gie_q),
        .status_o(isr_q), .irq_o(irq_o)
    );

    cstx_gsp_fifo #(.DEPTH(GSP_DEPTH), .W(PKT_W)) u_fifo (
        .clk(clk), .rst_n(rst_n),
        .push_i(gsp_wr && en_q && dt_ok), .data_i(req_pkt),
        .pop_i(gsp_pop_i), .head_o(head_pkt),
        .empty_o(fifo_empty), .full_o(fifo_full), .drop_o(fifo_drop),
        .count_o(fifo_cnt)
    );

    assign gsp_valid_o = !fifo_empty;
    assign gsp_pkt_o   = head_pkt;

    // Read data selection; unmapped offsets return zero.
    always_comb begin
        rd_data = '0;
        case (rd_ofs)
            OFS_CORE:  rd_data[4:0] = {clkm_s, lp_s, dp_ready_i, srst_q, en_q};
            OFS_PROTO: rd_data[15:0] = {lsync_s, PIX_CODE, 8'h00, MAX_CODE, 1'b0, lanes_s};
            OFS_GIE:   rd_data[0] = gie_q;
            OFS_ISR:   rd_data[NSTAT-1:0] = isr_q;
            OFS_IER:   rd_data[NSTAT-1:0] = ier_q;
            OFS_GSPST: rd_data[CNT_W+1:0] = {fifo_cnt, fifo_full, fifo_empty};
            default:   rd_data = '0;
        endcase
    end

    AST_EFF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |=> $stable(active_lanes_o) && $stable(line_sync_en_o)); // R4
    AST_GSP_DISCARD: assert property (@(posedge clk) disable iff (!rst_n)
        gsp_wr && !en_q && !gsp_pop_i |=> $stable(fifo_cnt));          // R9
    AST_PUSH_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_push |-> req_pkt.dt >= 6'h08 && req_pkt.dt <= 6'h0F);     // R9
    AST_IRQ_NEEDS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(|(isr_q & ier_q)));                    // R6
endmodule

// File: tb/cstx_regbank_bench.sv
`timescale 1ns/1ps
module cstx_regbank_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] awaddr = '0, araddr = '0;
    logic        awvalid = 1'b0, wvalid = 1'b0, arvalid = 1'b0;
    logic [31:0] wdata = '0;
    logic [3:0]  wstrb = 4'hF;
    logic        awready, wready, bvalid, arready, rvalid;
    logic [1:0]  bresp, rresp;
    logic [31:0] rdata;
    logic        dp_ready = 1'b1;
    logic        ev_und = 1'b0, ev_lb = 1'b0, ev_lp = 1'b0, pop = 1'b0;
    logic        core_en, lp_req, clk_nc, lsync, gsp_valid, irq;
    logic [1:0]  lanes;
    logic [23:0] gsp_pkt;
    int          n_chk = 0, n_fail = 0, cycles = 0;
    logic [31:0] rv;

    always #2 clk = ~clk;

    cstx_regbank u_cstx_regbank (
        .clk(clk), .rst_n(rst_n),
        .s_awaddr(awaddr), .s_awvalid(awvalid), .s_awready(awready),
        .s_wdata(wdata), .s_wstrb(wstrb), .s_wvalid(wvalid), .s_wready(wready),
        .s_bresp(bresp), .s_bvalid(bvalid), .s_bready(1'b1),
        .s_araddr(araddr), .s_arvalid(arvalid), .s_arready(arready),
        .s_rdata(rdata), .s_rresp(rresp), .s_rvalid(rvalid), .s_rready(1'b1),
        .dp_ready_i(dp_ready), .ev_underrun_i(ev_und),
        .ev_linebuf_full_i(ev_lb), .ev_lowpower_i(ev_lp),
        .core_en_o(core_en), .lp_req_o(lp_req), .clk_noncont_o(clk_nc),
        .line_sync_en_o(lsync), .active_lanes_o(lanes),
        .gsp_valid_o(gsp_valid), .gsp_pkt_o(gsp_pkt), .gsp_pop_i(pop),
        .irq_o(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        awaddr = a; wdata = d; awvalid = 1'b1; wvalid = 1'b1;
        @(posedge clk); #1;
        chk("R1 bresp", {30'b0, bresp}, 32'h0);
        @(negedge clk);
        awvalid = 1'b0; wvalid = 1'b0; wstrb = 4'hF;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        araddr = a; arvalid = 1'b1;
        @(posedge clk); #1;
        d = rdata;
        chk("R1 rresp", {30'b0, rresp}, 32'h0);
        @(negedge clk);
        arvalid = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_ev(input int which);
        @(negedge clk);
        case (which)
            0: ev_und = 1'b1;
            1: ev_lb = 1'b1;
            default: ev_lp = 1'b1;
        endcase
        @(negedge clk);
        ev_und = 1'b0; ev_lb = 1'b0; ev_lp = 1'b0;
    endtask

    task automatic pop_one;
        @(negedge clk); pop = 1'b1;
        @(negedge clk); pop = 1'b0;
    endtask

    task automatic t_reset;
        rd(12'h000, rv); chk("R2 core reset", rv, 32'h4);
        rd(12'h004, rv); chk("R3 proto reset", rv, 32'h9);
        rd(12'h078, rv); chk("R11 fifo reset", rv, 32'h1);
        chk("R7 irq reset", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_alias;
        rd(12'h080, rv); chk("R1 alias 0x80", rv, 32'h4);
        rd(12'h044, rv); chk("R1 unmapped", rv, 32'h0);
        wr(12'h0A8, 32'h3F);
        rd(12'h028, rv); chk("R1 alias write", rv, 32'h3F);
        wr(12'h028, 32'h0);
    endtask

    task automatic t_shadow;
        wr(12'h004, 32'h8000);
        rd(12'h004, rv); chk("R4 staged readback", rv, 32'h8008);
        idle(3);
        chk("R4 lanes held", {30'b0, lanes}, 32'h1);
        chk("R4 lsync held", {31'b0, lsync}, 32'h0);
        wr(12'h000, 32'h1);
        idle(2);
        chk("R4 lanes applied", {30'b0, lanes}, 32'h0);
        chk("R4 lsync applied", {31'b0, lsync}, 32'h1);
    endtask

    task automatic t_core;
        wstrb = 4'h0;
        wr(12'h000, 32'h19);
        rd(12'h000, rv); chk("R12 R2 core bits", rv, 32'h1D);
        idle(2);
        chk("R2 lp req", {31'b0, lp_req}, 32'h1);
        chk("R2 clk mode", {31'b0, clk_nc}, 32'h1);
        chk("R2 enable", {31'b0, core_en}, 32'h1);
        dp_ready = 1'b0;
        rd(12'h000, rv); chk("R2 ready mirror", rv, 32'h19);
        dp_ready = 1'b1;
        wr(12'h000, 32'h1);
    endtask

    task automatic t_isr;
        pulse_ev(0);
        rd(12'h024, rv); chk("R5 underrun", rv, 32'h1);
        pulse_ev(1); pulse_ev(2);
        rd(12'h024, rv); chk("R5 collect", rv, 32'hD);
        wr(12'h024, 32'h4);
        rd(12'h024, rv); chk("R5 w1c one", rv, 32'h9);
        wr(12'h024, 32'h0);
        rd(12'h024, rv); chk("R5 write zero", rv, 32'h9);
        wr(12'h024, 32'h3F);
        rd(12'h024, rv); chk("R5 w1c all", rv, 32'h0);
    endtask

    task automatic t_irq;
        wr(12'h020, 32'h1);
        pulse_ev(0);
        idle(2);
        rd(12'h024, rv); chk("R6 captured", rv, 32'h1);
        chk("R6 masked irq", {31'b0, irq}, 32'h0);
        wr(12'h028, 32'h1);
        idle(2);
        chk("R6 irq on", {31'b0, irq}, 32'h1);
        wr(12'h020, 32'h0);
        idle(2);
        chk("R7 gie off", {31'b0, irq}, 32'h0);
        wr(12'h020, 32'h1);
        idle(2);
        chk("R7 gie on", {31'b0, irq}, 32'h1);
        wr(12'h024, 32'h1);
        idle(2);
        chk("R5 irq clears", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_srst;
        pulse_ev(1);
        wr(12'h000, 32'h3);
        rd(12'h024, rv); chk("R8 cleared", rv, 32'h0);
        pulse_ev(0);
        rd(12'h024, rv); chk("R8 no capture", rv, 32'h0);
        wr(12'h000, 32'h1);
        pulse_ev(0);
        rd(12'h024, rv); chk("R8 resumed", rv, 32'h1);
        wr(12'h024, 32'h3F);
    endtask

    task automatic t_gsp;
        wr(12'h030, 32'h00BEEF8A);
        rd(12'h078, rv); chk("R9 queued", rv, 32'h4);
        chk("R9 head", {8'b0, gsp_pkt}, 32'h00BEEF8A);
        wr(12'h030, 32'h00123412);
        rd(12'h078, rv); chk("R9 bad type dropped", rv, 32'h4);
        rd(12'h024, rv); chk("R9 bad type status", rv, 32'h2);
        wr(12'h024, 32'h3F);
        wr(12'h000, 32'h0);
        wr(12'h030, 32'h00555509);
        rd(12'h078, rv); chk("R9 disabled discard", rv, 32'h4);
        rd(12'h024, rv); chk("R9 disabled no status", rv, 32'h0);
        wr(12'h000, 32'h1);
        pop_one;
        rd(12'h078, rv); chk("R11 popped empty", rv, 32'h1);
        chk("R11 valid low", {31'b0, gsp_valid}, 32'h0);
    endtask

    task automatic t_full;
        for (int i = 0; i < 4; i++) wr(12'h030, {8'h0, 8'hA0, 8'(i), 8'h08 + 8'(i)});
        rd(12'h078, rv); chk("R11 full status", rv, 32'h12);
        wr(12'h030, 32'h00FFFF0C);
        rd(12'h078, rv); chk("R11 overflow count", rv, 32'h12);
        rd(12'h024, rv); chk("R11 overflow status", rv, 32'h10);
        for (int i = 0; i < 4; i++) begin
            chk("R11 order", {8'b0, gsp_pkt}, {8'h0, 8'hA0, 8'(i), 8'h08 + 8'(i)});
            pop_one;
        end
        rd(12'h078, rv); chk("R11 drained", rv, 32'h1);
        wr(12'h024, 32'h3F);
    endtask

    task automatic t_lane;
        wr(12'h004, 32'h3);
        rd(12'h024, rv); chk("R10 bad lanes", rv, 32'h20);
        wr(12'h024, 32'h20);
        wr(12'h004, 32'h1);
        rd(12'h024, rv); chk("R10 legal lanes", rv, 32'h0);
    endtask

    initial begin : watchdog
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                n_chk++; n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
                $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
                $finish;
            end
        end
    end

    initial begin : main
        idle(3);
        @(negedge clk) rst_n = 1'b1;
        idle(1);
        t_reset;
        t_alias;
        t_shadow;
        t_core;
        t_isr;
        t_irq;
        t_srst;
        t_gsp;
        t_full;
        t_lane;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule